// File: doc/BRIEF.md
# Debug Command Transaction Sequencer

This block turns single debugger requests into the byte-level transactions that a two-wire debug port master carries out against an 8051-class target. Fixed-opcode requests (halt, resume, single step, status, chip erase, configuration access, chip identity and program counter) each become one port command. Memory requests become a short chain of real 8051 instructions. Each instruction is injected through a length-encoded debug-instruction command, and the target executes it and answers with its accumulator.

The host places an operation code, an address and a data byte on the request inputs and pulses `req_valid` while the block is idle. The block then drives the port master one byte at a time. Every byte is either sent or read back, and each is held until the master reports completion. The block collects the reply bytes and ends with a single-cycle `done` pulse. The result appears on `rsp_data`, and `err` is raised for an operation code the block does not know.

Top module: `dbg_cmd_sequencer`

## Requirements
- R1: A request is accepted only when `busy` and `done` are both low. While `busy` is high, `req_valid` has no effect, and `pt_valid` is never high while `busy` is low.
- R2: Operation codes 0 (halt), 1 (resume), 2 (step), 3 (status) and 8 (erase) each send one command byte: 0x44, 0x4C, 0x5C, 0x3F and 0x14 respectively. Each then reads one reply byte, returned as `rsp_data = {8'h00, reply}`.
- R3: Operation codes 4 (chip identity, command 0x68) and 5 (program counter, command 0x28) read two reply bytes. The first reply lands in `rsp_data[15:8]` and the second in `rsp_data[7:0]`.
- R4: Operation code 6 sends 0x24 and returns one reply byte in `rsp_data[7:0]`. Operation code 7 sends 0x1D followed by `req_wdata`, reads no reply and returns `rsp_data = 0`.
- R5: Each injected instruction of length L (1 to 3) is sent as the command byte 0x54+L, then its L instruction bytes in order. One reply byte is read after each instruction.
- R6: Operation code 9 (data read) injects 0x90,A[15:8],A[7:0], then 0xE0. The reply to 0xE0 is the result.
- R7: Operation code 10 (data write) injects 0x90,A[15:8],A[7:0], then 0x74,`req_wdata`, then 0xF0. The reply to 0xF0 is the result.
- R8: Operation code 11 (code read) injects 0x75,0xC7,M, then 0x90,A[15:8],A[7:0], then 0xE4, then 0x93, where M = ((A >> 15) << 4) + 1 taken to 8 bits. The reply to 0x93 is the result.
- R9: Operation code 12 (internal RAM read) injects 0xE4, then 0xE5,A[7:0]. Operation code 13 (internal RAM write) injects 0xE4, then 0x75,A[7:0],`req_wdata`. The reply to the last instruction is the result.
- R10: Operation codes 14 and 15 produce `done` with `err` high in the cycle after acceptance, with no port transfer and `busy` kept low. `err` is only ever high together with `done`.
- R11: `done` is a one-cycle pulse. For a known code, `busy` rises the cycle after acceptance and falls in the cycle `done` is high.
- R12: Once `pt_valid` is raised, it stays high with `pt_read` and `pt_wdata` unchanged until the master answers with `pt_done`. `pt_read` is high only for reply bytes, and `pt_rdata` is taken in the cycle `pt_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Target address (code, data or internal RAM) |
| req_wdata | input | 8 | Data byte for writes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unknown operation code, valid with done |
| rsp_data | output | 16 | Result, valid with done |
| pt_valid | output | 1 | Byte transfer requested from the port master |
| pt_read | output | 1 | 1: read a reply byte, 0: send pt_wdata |
| pt_wdata | output | 8 | Byte to send |
| pt_done | input | 1 | Port master finished the current byte |
| pt_rdata | input | 8 | Reply byte, valid with pt_done |

## Verification
The bench builds the block with `ADDR_W` = 18, so code addresses reach bank values above 1. A code read in bank 5 places 0x51 into the memory-control byte, and a bank-0 read gives 0x01. A port model with a two-cycle answer latency logs every sent byte and supplies reply bytes that count up from a per-request seed. This makes the position of the returned byte in each instruction chain and the byte order of two-byte replies directly visible.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  typedef enum logic [3:0] {
    OP_HALT   = 4'd0,
    OP_RESUME = 4'd1,
    OP_STEP   = 4'd2,
    OP_STATUS = 4'd3,
    OP_CHIPID = 4'd4,
    OP_GETPC  = 4'd5,
    OP_RDCFG  = 4'd6,
    OP_WRCFG  = 4'd7,
    OP_ERASE  = 4'd8,
    OP_XRD    = 4'd9,
    OP_XWR    = 4'd10,
    OP_CRD    = 4'd11,
    OP_IRD    = 4'd12,
    OP_IWR    = 4'd13
  } op_e;

  // debug port command bytes
  localparam logic [7:0] CMD_HALT   = 8'h44;
  localparam logic [7:0] CMD_RESUME = 8'h4C;
  localparam logic [7:0] CMD_STEP   = 8'h5C;
  localparam logic [7:0] CMD_STATUS = 8'h3F;
  localparam logic [7:0] CMD_CHIPID = 8'h68;
  localparam logic [7:0] CMD_GETPC  = 8'h28;
  localparam logic [7:0] CMD_RDCFG  = 8'h24;
  localparam logic [7:0] CMD_WRCFG  = 8'h1D;
  localparam logic [7:0] CMD_ERASE  = 8'h14;
  localparam logic [7:0] CMD_INJECT = 8'h54;

  // injected instruction bytes
  localparam logic [7:0] INS_LD_DPTR  = 8'h90;
  localparam logic [7:0] INS_XRD      = 8'hE0;
  localparam logic [7:0] INS_LD_ACC   = 8'h74;
  localparam logic [7:0] INS_XWR      = 8'hF0;
  localparam logic [7:0] INS_MOV_DIR  = 8'h75;
  localparam logic [7:0] INS_CLR_ACC  = 8'hE4;
  localparam logic [7:0] INS_RD_DIR   = 8'hE5;
  localparam logic [7:0] INS_CODE_RD  = 8'h93;
  localparam logic [7:0] SFR_BANKSEL  = 8'hC7;

  localparam int STEP_IDX_W = 2;

  typedef struct packed {
    logic [7:0] cmd;
    logic [1:0] nargs;
    logic [7:0] a0;
    logic [7:0] a1;
    logic [7:0] a2;
    logic [1:0] nrep;
    logic       last;
  } step_t;

  function automatic logic op_known(input logic [3:0] op);
    return op <= OP_IWR;
  endfunction

  function automatic step_t cmd_step(input logic [7:0] c, input logic [1:0] nargs,
                                     input logic [7:0] arg, input logic [1:0] nrep);
    step_t s;
    s.cmd   = c;
    s.nargs = nargs;
    s.a0    = arg;
    s.a1    = 8'h00;
    s.a2    = 8'h00;
    s.nrep  = nrep;
    s.last  = 1'b1;
    return s;
  endfunction

  function automatic step_t ins_step(input logic [1:0] len, input logic [7:0] b0,
                                     input logic [7:0] b1, input logic [7:0] b2,
                                     input logic last);
    step_t s;
    s.cmd   = CMD_INJECT + {6'd0, len};
    s.nargs = len;
    s.a0    = b0;
    s.a1    = b1;
    s.a2    = b2;
    s.nrep  = 2'd1;
    s.last  = last;
    return s;
  endfunction

endpackage

// File: rtl/dbgseq_prog.sv
module dbgseq_prog
  import dbgseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [3:0]            op,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  input  logic [STEP_IDX_W-1:0] idx,
  output step_t                 step
);

  localparam int BANK_SHIFT = 15;

  logic [ADDR_W-1:0] bank_full;
  logic [7:0]        bank_sel;
  logic [7:0]        a_hi;
  logic [7:0]        a_lo;

  always_comb begin
    bank_full = addr >> BANK_SHIFT;
    bank_sel  = {bank_full[3:0], 4'h1};
    a_hi      = addr[15:8];
    a_lo      = addr[7:0];
  end

  always_comb begin
    step = cmd_step(8'h00, 2'd0, 8'h00, 2'd0);
    case (op)
      OP_HALT:   step = cmd_step(CMD_HALT,   2'd0, 8'h00, 2'd1);
      OP_RESUME: step = cmd_step(CMD_RESUME, 2'd0, 8'h00, 2'd1);
      OP_STEP:   step = cmd_step(CMD_STEP,   2'd0, 8'h00, 2'd1);
      OP_STATUS: step = cmd_step(CMD_STATUS, 2'd0, 8'h00, 2'd1);
      OP_ERASE:  step = cmd_step(CMD_ERASE,  2'd0, 8'h00, 2'd1);
      OP_CHIPID: step = cmd_step(CMD_CHIPID, 2'd0, 8'h00, 2'd2);
      OP_GETPC:  step = cmd_step(CMD_GETPC,  2'd0, 8'h00, 2'd2);
      OP_RDCFG:  step = cmd_step(CMD_RDCFG,  2'd0, 8'h00, 2'd1);
      OP_WRCFG:  step = cmd_step(CMD_WRCFG,  2'd1, wdata, 2'd0);
      OP_XRD: begin
        if (idx == 2'd0) step = ins_step(2'd3, INS_LD_DPTR, a_hi, a_lo, 1'b0);
        else             step = ins_step(2'd1, INS_XRD, 8'h00, 8'h00, 1'b1);
      end
      OP_XWR: begin
        case (idx)
          2'd0:    step = ins_step(2'd3, INS_LD_DPTR, a_hi, a_lo, 1'b0);
          2'd1:    step = ins_step(2'd2, INS_LD_ACC, wdata, 8'h00, 1'b0);
          default: step = ins_step(2'd1, INS_XWR, 8'h00, 8'h00, 1'b1);
        endcase
      end
      OP_CRD: begin
        case (idx)
          2'd0:    step = ins_step(2'd3, INS_MOV_DIR, SFR_BANKSEL, bank_sel, 1'b0);
          2'd1:    step = ins_step(2'd3, INS_LD_DPTR, a_hi, a_lo, 1'b0);
          2'd2:    step = ins_step(2'd1, INS_CLR_ACC, 8'h00, 8'h00, 1'b0);
          default: step = ins_step(2'd1, INS_CODE_RD, 8'h00, 8'h00, 1'b1);
        endcase
      end
      OP_IRD: begin
        if (idx == 2'd0) step = ins_step(2'd1, INS_CLR_ACC, 8'h00, 8'h00, 1'b0);
        else             step = ins_step(2'd2, INS_RD_DIR, a_lo, 8'h00, 1'b1);
      end
      OP_IWR: begin
        if (idx == 2'd0) step = ins_step(2'd1, INS_CLR_ACC, 8'h00, 8'h00, 1'b0);
        else             step = ins_step(2'd3, INS_MOV_DIR, a_lo, wdata, 1'b1);
      end
      default: step = cmd_step(8'h00, 2'd0, 8'h00, 2'd0);
    endcase
  end

endmodule

// File: rtl/dbgseq_engine.sv
module dbgseq_engine
  import dbgseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  step_t       step,
  output logic        fin,
  output logic [15:0] reply,
  output logic        pt_valid,
  output logic        pt_read,
  output logic [7:0]  pt_wdata,
  input  logic        pt_done,
  input  logic [7:0]  pt_rdata
);

  typedef enum logic [1:0] {E_IDLE, E_CMD, E_ARG, E_REP} est_e;

  est_e       st_q, st_d;
  step_t      cur_q, cur_d;
  logic [1:0] aidx_q, aidx_d;
  logic [1:0] ridx_q, ridx_d;
  logic [15:0] shr_q, shr_d;
  logic       fin_q, fin_d;
  logic       xfer;
  logic [1:0] aidx_nx;
  logic [1:0] ridx_nx;

  always_comb begin
    xfer    = pt_valid && pt_done;
    aidx_nx = 2'(aidx_q + 2'd1);
    ridx_nx = 2'(ridx_q + 2'd1);
    st_d    = st_q;
    cur_d   = cur_q;
    aidx_d  = aidx_q;
    ridx_d  = ridx_q;
    shr_d   = shr_q;
    fin_d   = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (start) begin
          cur_d  = step;
          aidx_d = 2'd0;
          ridx_d = 2'd0;
          shr_d  = 16'h0000;
          st_d   = E_CMD;
        end
      end
      E_CMD: begin
        if (xfer) begin
          if (cur_q.nargs != 2'd0)     st_d = E_ARG;
          else if (cur_q.nrep != 2'd0) st_d = E_REP;
          else begin
            st_d  = E_IDLE;
            fin_d = 1'b1;
          end
        end
      end
      E_ARG: begin
        if (xfer) begin
          aidx_d = aidx_nx;
          if (aidx_nx == cur_q.nargs) begin
            if (cur_q.nrep != 2'd0) st_d = E_REP;
            else begin
              st_d  = E_IDLE;
              fin_d = 1'b1;
            end
          end
        end
      end
      E_REP: begin
        if (xfer) begin
          shr_d  = {shr_q[7:0], pt_rdata};
          ridx_d = ridx_nx;
          if (ridx_nx == cur_q.nrep) begin
            st_d  = E_IDLE;
            fin_d = 1'b1;
          end
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cur_q  <= '0;
      aidx_q <= 2'd0;
      ridx_q <= 2'd0;
      shr_q  <= 16'h0000;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      fin_q  <= fin_d;
      if (start && st_q == E_IDLE) cur_q <= cur_d;
      if (start || xfer) begin
        aidx_q <= aidx_d;
        ridx_q <= ridx_d;
        shr_q  <= shr_d;
      end
    end
  end

  always_comb begin
    pt_valid = (st_q != E_IDLE);
    pt_read  = (st_q == E_REP);
    case (st_q)
      E_CMD:   pt_wdata = cur_q.cmd;
      E_ARG: begin
        case (aidx_q)
          2'd0:    pt_wdata = cur_q.a0;
          2'd1:    pt_wdata = cur_q.a1;
          default: pt_wdata = cur_q.a2;
        endcase
      end
      default: pt_wdata = 8'h00;
    endcase
    fin   = fin_q;
    reply = shr_q;
  end

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_valid && !pt_done) |=> (pt_valid && $stable(pt_wdata) && $stable(pt_read)))
    else $error("port byte changed before completion"); // R12

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pt_valid)
    else $error("engine started while a transfer is open"); // R1

endmodule

// File: rtl/dbg_cmd_sequencer.sv
module dbg_cmd_sequencer
  import dbgseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [15:0]       rsp_data,
  output logic              pt_valid,
  output logic              pt_read,
  output logic [7:0]        pt_wdata,
  input  logic              pt_done,
  input  logic [7:0]        pt_rdata
);

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} tst_e;

  logic [1:0]              rsync_q;
  logic                    rst_sn;
  tst_e                    st_q, st_d;
  logic [3:0]              op_q, op_d;
  logic [ADDR_W-1:0]       addr_q, addr_d;
  logic [7:0]              wd_q, wd_d;
  logic [STEP_IDX_W-1:0]   sidx_q, sidx_d;
  logic                    done_q, done_d;
  logic                    err_q, err_d;
  logic [15:0]             rsp_q, rsp_d;
  logic                    accept;
  logic                    eng_start;
  logic                    eng_fin;
  logic [15:0]             eng_reply;
  step_t                   cur_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  dbgseq_prog #(.ADDR_W(ADDR_W)) u_prog (
    .op    (op_q),
    .addr  (addr_q),
    .wdata (wd_q),
    .idx   (sidx_q),
    .step  (cur_step)
  );

  dbgseq_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (eng_start),
    .step     (cur_step),
    .fin      (eng_fin),
    .reply    (eng_reply),
    .pt_valid (pt_valid),
    .pt_read  (pt_read),
    .pt_wdata (pt_wdata),
    .pt_done  (pt_done),
    .pt_rdata (pt_rdata)
  );

  always_comb begin
    accept    = req_valid && (st_q == T_IDLE) && !done_q;
    st_d      = st_q;
    op_d      = op_q;
    addr_d    = addr_q;
    wd_d      = wd_q;
    sidx_d    = sidx_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    rsp_d     = rsp_q;
    eng_start = 1'b0;
    case (st_q)
      T_IDLE: begin
        if (accept) begin
          op_d   = req_op;
          addr_d = req_addr;
          wd_d   = req_wdata;
          sidx_d = '0;
          if (op_known(req_op)) begin
            st_d = T_ISSUE;
          end else begin
            done_d = 1'b1;
            err_d  = 1'b1;
            rsp_d  = 16'h0000;
          end
        end
      end
      T_ISSUE: begin
        eng_start = 1'b1;
        st_d      = T_WAIT;
      end
      T_WAIT: begin
        if (eng_fin) begin
          if (cur_step.last) begin
            done_d = 1'b1;
            rsp_d  = eng_reply;
            st_d   = T_IDLE;
          end else begin
            sidx_d = STEP_IDX_W'(sidx_q + 1'b1);
            st_d   = T_ISSUE;
          end
        end
      end
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= T_IDLE;
      op_q   <= 4'd0;
      addr_q <= '0;
      wd_q   <= 8'h00;
      sidx_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rsp_q  <= 16'h0000;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (accept) begin
        op_q   <= op_d;
        addr_q <= addr_d;
        wd_q   <= wd_d;
      end
      if (accept || eng_fin) sidx_q <= sidx_d;
      if (done_d) rsp_q <= rsp_d;
    end
  end

  assign busy     = (st_q != T_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign rsp_data = rsp_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> !pt_valid)
    else $error("port active while idle"); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && !busy && !done && op_known(req_op)) |=> busy)
    else $error("known request not taken"); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done)
    else $error("done longer than one cycle"); // R11

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    err |-> done)
    else $error("err without done"); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !busy)
    else $error("done while still busy"); // R11

endmodule

// File: tb/dbg_cmd_sequencer_bench.sv
`timescale 1ns/1ps
module dbg_cmd_sequencer_bench;

  localparam int AW  = 18;
  localparam int LAT = 2;
  localparam int NV  = 15;

  typedef struct packed {
    logic [3:0]    op;
    logic [AW-1:0] addr;
    logic [7:0]    wd;
    logic [7:0]    seed;
    logic [3:0]    ntx;
    logic [95:0]   tx;
    logic [2:0]    nrd;
    logic [15:0]   rsp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd0,  18'h00000, 8'h00, 8'h10, 4'd1,  96'h44_00_00_00_00_00_00_00_00_00_00_00, 3'd1, 16'h0010},
    '{4'd1,  18'h00000, 8'h00, 8'h21, 4'd1,  96'h4C_00_00_00_00_00_00_00_00_00_00_00, 3'd1, 16'h0021},
    '{4'd2,  18'h00000, 8'h00, 8'h32, 4'd1,  96'h5C_00_00_00_00_00_00_00_00_00_00_00, 3'd1, 16'h0032},
    '{4'd3,  18'h00000, 8'h00, 8'h43, 4'd1,  96'h3F_00_00_00_00_00_00_00_00_00_00_00, 3'd1, 16'h0043},
    '{4'd4,  18'h00000, 8'h00, 8'hA5, 4'd1,  96'h68_00_00_00_00_00_00_00_00_00_00_00, 3'd2, 16'hA5A6},
    '{4'd5,  18'h00000, 8'h00, 8'h7E, 4'd1,  96'h28_00_00_00_00_00_00_00_00_00_00_00, 3'd2, 16'h7E7F},
    '{4'd6,  18'h00000, 8'h00, 8'h55, 4'd1,  96'h24_00_00_00_00_00_00_00_00_00_00_00, 3'd1, 16'h0055},
    '{4'd7,  18'h00000, 8'h3C, 8'h99, 4'd2,  96'h1D_3C_00_00_00_00_00_00_00_00_00_00, 3'd0, 16'h0000},
    '{4'd8,  18'h00000, 8'h00, 8'h66, 4'd1,  96'h14_00_00_00_00_00_00_00_00_00_00_00, 3'd1, 16'h0066},
    '{4'd9,  18'h0F123, 8'h00, 8'h80, 4'd6,  96'h57_90_F1_23_55_E0_00_00_00_00_00_00, 3'd2, 16'h0081},
    '{4'd10, 18'h0F800, 8'hC3, 8'h90, 4'd9,  96'h57_90_F8_00_56_74_C3_55_F0_00_00_00, 3'd3, 16'h0092},
    '{4'd11, 18'h2ABCD, 8'h00, 8'hB0, 4'd12, 96'h57_75_C7_51_57_90_AB_CD_55_E4_55_93, 3'd4, 16'h00B3},
    '{4'd11, 18'h00042, 8'h00, 8'h01, 4'd12, 96'h57_75_C7_01_57_90_00_42_55_E4_55_93, 3'd4, 16'h0004},
    '{4'd12, 18'h0007F, 8'h00, 8'hC8, 4'd5,  96'h55_E4_56_E5_7F_00_00_00_00_00_00_00, 3'd2, 16'h00C9},
    '{4'd13, 18'h00030, 8'h5A, 8'hD0, 4'd6,  96'h55_E4_57_75_30_5A_00_00_00_00_00_00, 3'd2, 16'h00D1}
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [3:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_wdata;
  logic          busy, done, err;
  logic [15:0]   rsp_data;
  logic          pt_valid, pt_read;
  logic [7:0]    pt_wdata;
  logic          pt_done;
  logic [7:0]    pt_rdata;

  int checks = 0;
  int fails  = 0;

  dbg_cmd_sequencer #(.ADDR_W(AW)) u_dbg_cmd_sequencer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rsp_data(rsp_data),
    .pt_valid(pt_valid), .pt_read(pt_read), .pt_wdata(pt_wdata),
    .pt_done(pt_done), .pt_rdata(pt_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // port master model
  logic [7:0] tx_log [512];
  int tx_cnt = 0;
  int rd_cnt = 0;
  int rd_base = 0;
  logic [7:0] cur_seed = 8'h00;
  int lat = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_done  <= 1'b0;
      pt_rdata <= 8'h00;
      lat      <= 0;
    end else if (pt_done) begin
      pt_done <= 1'b0;
      lat     <= 0;
    end else if (pt_valid) begin
      if (lat == LAT) begin
        pt_done <= 1'b1;
        if (pt_read) begin
          pt_rdata <= cur_seed + 8'(rd_cnt - rd_base);
          rd_cnt   <= rd_cnt + 1;
        end else begin
          tx_log[tx_cnt % 512] <= pt_wdata;
          tx_cnt <= tx_cnt + 1;
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // R12 handshake monitor
  int hold_viol = 0;
  logic       pv_open = 1'b0;
  logic [7:0] pv_wd   = 8'h00;
  logic       pv_rd   = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv_open && !(pt_valid && pt_wdata == pv_wd && pt_read == pv_rd))
        hold_viol = hold_viol + 1;
      pv_open = pt_valid && !pt_done;
      pv_wd   = pt_wdata;
      pv_rd   = pt_read;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd8: return "R2";
      4'd4, 4'd5:                   return "R3";
      4'd6, 4'd7:                   return "R4";
      4'd9:                         return "R6 R5";
      4'd10:                        return "R7 R5";
      4'd11:                        return "R8 R5";
      default:                      return "R9 R5";
    endcase
  endfunction

  logic [15:0] got_rsp;
  logic        got_err;
  logic        got_busy;
  int          tx_base;
  int          rd_start;

  task automatic run_req(input logic [3:0] op, input logic [AW-1:0] a,
                         input logic [7:0] wd, input logic [7:0] seed);
    int wait_cnt;
    @(negedge clk);
    tx_base   = tx_cnt;
    rd_start  = rd_cnt;
    rd_base   = rd_cnt;
    cur_seed  = seed;
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    wait_cnt  = 0;
    while (!done && wait_cnt < 2000) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk(wait_cnt < 2000, "R11 timeout", 96'(wait_cnt), 96'd2000);
    got_rsp  = rsp_data;
    got_err  = err;
    got_busy = busy;
  endtask

  function automatic logic [95:0] log_bytes(input int base, input int n);
    logic [95:0] v = '0;
    for (int i = 0; i < n && i < 12; i++) v[95 - 8*i -: 8] = tx_log[(base + i) % 512];
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_op    = 4'd0;
    req_addr  = '0;
    req_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R11, R1)
    chk(!busy && !done && !err, "R11 reset", {93'd0, busy, done, err}, 96'd0);
    chk(!pt_valid, "R1 reset port", 96'(pt_valid), 96'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v].op, VEC[v].addr, VEC[v].wd, VEC[v].seed);
      chk(tx_cnt - tx_base == int'(VEC[v].ntx), tag_of(VEC[v].op),
          96'(tx_cnt - tx_base), 96'(VEC[v].ntx));
      chk(log_bytes(tx_base, int'(VEC[v].ntx)) == VEC[v].tx, tag_of(VEC[v].op),
          log_bytes(tx_base, int'(VEC[v].ntx)), VEC[v].tx);
      chk(rd_cnt - rd_start == int'(VEC[v].nrd), tag_of(VEC[v].op),
          96'(rd_cnt - rd_start), 96'(VEC[v].nrd));
      chk(got_rsp == VEC[v].rsp, "R11 result", 96'(got_rsp), 96'(VEC[v].rsp));
      chk(!got_err && !got_busy, "R11 busy/err at done", {94'd0, got_err, got_busy}, 96'd0);
      @(negedge clk);
      chk(!done, "R11 done one cycle", 96'(done), 96'd0);
    end

    // R10: unknown operation codes
    for (int u = 14; u < 16; u++) begin
      run_req(4'(u), 18'h00000, 8'h00, 8'h00);
      chk(got_err, "R10 err flag", 96'(got_err), 96'd1);
      chk(!got_busy, "R10 busy stays low", 96'(got_busy), 96'd0);
      repeat (10) @(negedge clk);
      chk(tx_cnt == tx_base && rd_cnt == rd_start, "R10 no port traffic",
          96'(tx_cnt - tx_base), 96'd0);
    end

    // R1: request while busy is ignored
    @(negedge clk);
    tx_base   = tx_cnt;
    rd_start  = rd_cnt;
    rd_base   = rd_cnt;
    cur_seed  = 8'h40;
    req_valid = 1'b1;
    req_op    = 4'd9;
    req_addr  = 18'h01234;
    @(negedge clk);
    req_op    = 4'd0;
    repeat (3) @(negedge clk);
    chk(busy, "R1 busy during request", 96'(busy), 96'd1);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    got_rsp = rsp_data;
    repeat (20) @(negedge clk);
    chk(tx_cnt - tx_base == 6, "R1 ignored request", 96'(tx_cnt - tx_base), 96'd6);
    chk(log_bytes(tx_base, 6) == 96'h57_90_12_34_55_E0_00_00_00_00_00_00, "R1 ignored request",
        log_bytes(tx_base, 6), 96'h57_90_12_34_55_E0_00_00_00_00_00_00);
    chk(got_rsp == 16'h0041, "R1 result", 96'(got_rsp), 96'h41);

    // R12 handshake
    chk(hold_viol == 0, "R12 byte held", 96'(hold_viol), 96'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule